// File: doc/BRIEF.md
# Redundant Reference Clock Failover

This block takes two reference clocks, `ref_a` and `ref_b`, and drives a single output clock from one of them. A static select input says which of the two is the primary; the other is the backup. Both references are nominally 13 MHz and lie within about ±0.4 MHz of each other. A free-running system clock, much faster than the references, watches each reference for activity. When the primary goes quiet, the output moves to the backup. When the primary comes back, the output returns to it only after the primary has run without a break for a fixed number of its own cycles.

Every handover is free of glitches. The enable of the outgoing input is withdrawn on that input's falling edge. The enable of the incoming input is raised on its own falling edge, and only after the outgoing enable is seen to be off. The output therefore never shows a phase shorter than half a reference period. An input that stops while it drives the output, whether stuck high or stuck low, has its enable cleared at once when its loss is declared. A stalled clock can then never keep the output high.

A status bus shows which input currently drives the output. A one-cycle event pulse marks every switchover.

Top module: `refclk_failover`

## Requirements
- R1: While `rst_n` is low, `clk_out` is 0, `active_src` is 2'b00 and `switch_evt` is 0, whichever references are toggling.
- R2: A reference with no edge, rising or falling, for `LOSS_TIMEOUT` system-clock cycles is declared lost. If it is the active input, the output moves to the other input when that input is alive. A lost input's enable is cleared even if the input is stuck high.
- R3: The enables of the two inputs are never on together. No high or low phase of `clk_out` is shorter than half the period of the faster reference, including across a handover or the loss of an input.
- R4: When the primary returns after a loss, it drives the output again only after `QUAL_CYCLES` (default 1024) of its rising edges, counted while it stays active. Until then the backup stays selected.
- R5: If the returning primary is lost again before the qualification count completes, the count restarts from zero.
- R6: When neither input is usable, `clk_out` is held low and `active_src` reads 2'b00. A backup that later starts toggling is taken up without qualification.
- R7: At reset release the block watches both inputs for `LOSS_TIMEOUT` cycles. It then selects the primary if it is running, otherwise the backup, with no qualification in either case.
- R8: `pri_is_a` = 1 makes `ref_a` the primary and `pri_is_a` = 0 makes `ref_b` the primary. A change of `pri_is_a` clears the qualification count and moves the output to the new primary through the glitch-free handover if that input is alive.
- R9: `active_src` encodes the driving input as 2'b01 for `ref_a`, 2'b10 for `ref_b` and 2'b00 for none. `switch_evt` is high for exactly one system-clock cycle, in the cycle where `active_src` takes a new non-zero value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | Free-running monitor clock, at least 4x the reference frequency |
| rst_n | input | 1 | Active-low asynchronous reset |
| pri_is_a | input | 1 | Static select: 1 makes `ref_a` the primary, 0 makes `ref_b` the primary |
| ref_a | input | 1 | Reference clock A |
| ref_b | input | 1 | Reference clock B |
| clk_out | output | 1 | Glitch-free output clock |
| active_src | output | 2 | Driving input: 01 is A, 10 is B, 00 is none |
| switch_evt | output | 1 | One-cycle pulse when a new input takes over the output |

## Verification
The assertions watch, on every system-clock cycle, the properties that hold at all times. The two enables are never on together. A lost input's enable is seen cleared within the synchronizer delay. A loss is declared only after a full quiet window. A return from the backup to the primary happens only with a complete qualification count or a select change. The event pulse lasts one cycle. Only the bench's scenarios can show the timed behaviour: the width of every output phase across handovers and stuck-high losses, the qualification window measured in reference periods, the count restarting after an interrupted return, the start-up choice when the primary is dead, and the output held low with both inputs silent.

// File: rtl/refsw_pkg.sv
package refsw_pkg;

    // Controller states: which role currently drives the output.
    typedef enum logic [1:0] {
        ST_START = 2'd0,
        ST_PRI   = 2'd1,
        ST_BAK   = 2'd2,
        ST_NONE  = 2'd3
    } sw_state_e;

    // Source indices used on every two-bit source vector.
    localparam int SRC_A   = 0;
    localparam int SRC_B   = 1;
    localparam int NUM_SRC = 2;

endpackage

// File: rtl/refsw_bit_sync.sv
module refsw_bit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/refsw_act_monitor.sv
module refsw_act_monitor #(
    parameter int LOSS_TIMEOUT = 16,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_i,
    output logic alive_o,
    output logic rise_o
);
    localparam int IW = $clog2(LOSS_TIMEOUT + 1);
    localparam logic [IW-1:0] IDLE_MAX = IW'(LOSS_TIMEOUT);

    typedef struct packed {
        logic          prev;
        logic [IW-1:0] idle;
        logic          alive;
        logic          rise;
    } mon_t;

    mon_t r_d, r_q;
    logic sync_s;
    logic toggle;

    refsw_bit_sync #(.STAGES(SYNC_STAGES)) u_ref_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ref_i),
        .q     (sync_s)
    );

    always_comb begin
        r_d      = r_q;
        toggle   = sync_s ^ r_q.prev;
        r_d.prev = sync_s;
        r_d.rise = sync_s & ~r_q.prev;
        if (toggle)
            r_d.idle = '0;
        else if (r_q.idle != IDLE_MAX)
            r_d.idle = r_q.idle + 1'b1;
        r_d.alive = (r_d.idle != IDLE_MAX);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.prev  <= 1'b0;
            r_q.idle  <= IDLE_MAX;
            r_q.alive <= 1'b0;
            r_q.rise  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign alive_o = r_q.alive;
    assign rise_o  = r_q.rise;

    // R2: a loss is declared only at the end of a complete quiet window
    a_r2_full_quiet_window: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_q.alive) |-> ($past(r_q.idle) == IW'(LOSS_TIMEOUT - 1)));
endmodule

// File: rtl/refsw_gate_cell.sv
module refsw_gate_cell #(
    parameter int STAGES = 2
) (
    input  logic ref_clk,
    input  logic clr_n,
    input  logic req_i,
    output logic en_o,
    output logic gclk_o
);
    logic [STAGES-1:0] en_d, en_q;

    always_comb begin
        en_d = {en_q[STAGES-2:0], req_i};
    end

    // Enable changes only while the reference is low; a lost reference is
    // cleared asynchronously so a stalled high level cannot hold the output.
    always_ff @(negedge ref_clk or negedge clr_n) begin
        if (!clr_n) en_q <= '0;
        else        en_q <= en_d;
    end

    assign en_o   = en_q[STAGES-1];
    assign gclk_o = ref_clk & en_q[STAGES-1];
endmodule

// File: rtl/refsw_ctrl.sv
module refsw_ctrl
    import refsw_pkg::*;
#(
    parameter int LOSS_TIMEOUT = 16,
    parameter int QUAL_CYCLES  = 1024
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pri_is_a_s,
    input  logic [1:0] alive_i,
    input  logic [1:0] rise_i,
    input  logic [1:0] en_s_i,
    output logic [1:0] req_o,
    output logic [1:0] act_o,
    output logic       evt_o
);
    localparam int CW = $clog2(QUAL_CYCLES + 1);
    localparam int WW = $clog2(LOSS_TIMEOUT + 1);
    localparam logic [CW-1:0] QUAL_MAX = CW'(QUAL_CYCLES);
    localparam logic [WW-1:0] WIN_MAX  = WW'(LOSS_TIMEOUT);

    typedef struct packed {
        sw_state_e     st;
        logic [CW-1:0] qual;
        logic [WW-1:0] win;
        logic          sel_prev;
        logic [1:0]    want;
        logic [1:0]    req;
        logic [1:0]    act;
        logic          evt;
    } ctrl_t;

    ctrl_t r_d, r_q;
    logic  pri_idx, bak_idx;
    logic  pri_alive, bak_alive, pri_rise;
    logic  qual_full, sel_chg;

    always_comb begin
        pri_idx   = pri_is_a_s ? 1'(SRC_A) : 1'(SRC_B);
        bak_idx   = ~pri_idx;
        pri_alive = alive_i[pri_idx];
        bak_alive = alive_i[bak_idx];
        pri_rise  = rise_i[pri_idx];
        qual_full = (r_q.qual == QUAL_MAX);
        sel_chg   = (pri_is_a_s != r_q.sel_prev);

        r_d          = r_q;
        r_d.sel_prev = pri_is_a_s;

        // Qualification of the primary: consecutive rising edges while active.
        if (!pri_alive)
            r_d.qual = '0;
        else if (pri_rise && !qual_full)
            r_d.qual = r_q.qual + 1'b1;

        unique case (r_q.st)
            ST_START: begin
                if (r_q.win == WIN_MAX)
                    r_d.st = pri_alive ? ST_PRI : (bak_alive ? ST_BAK : ST_NONE);
                else
                    r_d.win = r_q.win + 1'b1;
            end
            ST_PRI: begin
                if (!pri_alive)
                    r_d.st = bak_alive ? ST_BAK : ST_NONE;
            end
            ST_BAK: begin
                if (pri_alive && qual_full)
                    r_d.st = ST_PRI;
                else if (!bak_alive)
                    r_d.st = ST_NONE;
            end
            ST_NONE: begin
                if (pri_alive && qual_full)
                    r_d.st = ST_PRI;
                else if (bak_alive)
                    r_d.st = ST_BAK;
            end
            default: r_d.st = ST_START;
        endcase

        // A new primary choice acts like a loss of the old one.
        if (r_q.st != ST_START && sel_chg) begin
            r_d.qual = '0;
            r_d.st   = pri_alive ? ST_PRI : (bak_alive ? ST_BAK : ST_NONE);
        end

        if (r_d.st == ST_PRI)
            r_d.qual = '0;

        // Target input as a one-hot vector indexed by source.
        r_d.want = 2'b00;
        if (r_d.st == ST_PRI) r_d.want[pri_idx] = 1'b1;
        if (r_d.st == ST_BAK) r_d.want[bak_idx] = 1'b1;

        // Handshake: request an input only once the other enable is seen off.
        r_d.req[SRC_A] = r_q.want[SRC_A] & ~en_s_i[SRC_B];
        r_d.req[SRC_B] = r_q.want[SRC_B] & ~en_s_i[SRC_A];

        r_d.act = en_s_i;
        r_d.evt = (en_s_i != r_q.act) && (en_s_i != 2'b00);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st       <= ST_START;
            r_q.qual     <= '0;
            r_q.win      <= '0;
            r_q.sel_prev <= 1'b0;
            r_q.want     <= 2'b00;
            r_q.req      <= 2'b00;
            r_q.act      <= 2'b00;
            r_q.evt      <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_o = r_q.req;
    assign act_o = r_q.act;
    assign evt_o = r_q.evt;

    // R4: return from the backup or from idle needs a full count, unless the select changed
    a_r4_requalified: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_PRI && ($past(r_q.st) == ST_BAK || $past(r_q.st) == ST_NONE)
         && ($past(pri_is_a_s) == $past(r_q.sel_prev)))
        |-> ($past(r_q.qual) == QUAL_MAX));

    // R9: the switchover event is a single-cycle pulse
    a_r9_evt_single: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.evt |=> !r_q.evt);

    // R6: with no usable input for three cycles, no input is requested
    a_r6_idle_no_request: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_NONE && $past(r_q.st) == ST_NONE && $past(r_q.st, 2) == ST_NONE)
        |-> (r_q.req == 2'b00));
endmodule

// File: rtl/refclk_failover.sv
module refclk_failover
    import refsw_pkg::*;
#(
    parameter int LOSS_TIMEOUT = 16,
    parameter int QUAL_CYCLES  = 1024,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       sys_clk,
    input  logic       rst_n,
    input  logic       pri_is_a,
    input  logic       ref_a,
    input  logic       ref_b,
    output logic       clk_out,
    output logic [1:0] active_src,
    output logic       switch_evt
);
    localparam int DRW     = $clog2(SYNC_STAGES + 3);
    localparam int DR_NEED = SYNC_STAGES + 1;

    logic [NUM_SRC-1:0] ref_vec, alive, rise, en_raw, en_s, req, gclk, clr_n;
    logic               sel_s;

    assign ref_vec = {ref_b, ref_a};

    refsw_bit_sync #(.STAGES(SYNC_STAGES)) u_sel_sync (
        .clk   (sys_clk),
        .rst_n (rst_n),
        .d     (pri_is_a),
        .q     (sel_s)
    );

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        refsw_act_monitor #(
            .LOSS_TIMEOUT (LOSS_TIMEOUT),
            .SYNC_STAGES  (SYNC_STAGES)
        ) u_mon (
            .clk     (sys_clk),
            .rst_n   (rst_n),
            .ref_i   (ref_vec[i]),
            .alive_o (alive[i]),
            .rise_o  (rise[i])
        );

        assign clr_n[i] = rst_n & alive[i];

        refsw_gate_cell #(.STAGES(SYNC_STAGES)) u_gate (
            .ref_clk (ref_vec[i]),
            .clr_n   (clr_n[i]),
            .req_i   (req[i]),
            .en_o    (en_raw[i]),
            .gclk_o  (gclk[i])
        );

        refsw_bit_sync #(.STAGES(SYNC_STAGES)) u_en_sync (
            .clk   (sys_clk),
            .rst_n (rst_n),
            .d     (en_raw[i]),
            .q     (en_s[i])
        );

        // Consecutive-loss counter feeding the checker below.
        logic [DRW-1:0] dr_d, dr_q;
        always_comb begin
            if (alive[i])                   dr_d = '0;
            else if (dr_q != DRW'(DR_NEED)) dr_d = dr_q + 1'b1;
            else                            dr_d = dr_q;
        end
        always_ff @(posedge sys_clk or negedge rst_n) begin
            if (!rst_n) dr_q <= '0;
            else        dr_q <= dr_d;
        end

        // R2: a lost input's enable is seen off once the sync delay has passed
        a_r2_lost_input_disabled: assert property (@(posedge sys_clk) disable iff (!rst_n)
            (dr_q == DRW'(DR_NEED)) |-> !en_s[i]);
    end

    refsw_ctrl #(
        .LOSS_TIMEOUT (LOSS_TIMEOUT),
        .QUAL_CYCLES  (QUAL_CYCLES)
    ) u_ctrl (
        .clk        (sys_clk),
        .rst_n      (rst_n),
        .pri_is_a_s (sel_s),
        .alive_i    (alive),
        .rise_i     (rise),
        .en_s_i     (en_s),
        .req_o      (req),
        .act_o      (active_src),
        .evt_o      (switch_evt)
    );

    assign clk_out = |gclk;

    // R3: the two enables are never on together
    a_r3_one_enable: assert property (@(posedge sys_clk) disable iff (!rst_n)
        $onehot0(en_s));
endmodule

// File: tb/refclk_failover_bench.sv
`timescale 1ns/1ps
module refclk_failover_bench;
    localparam real SYS_HALF = 2.5;    // 200 MHz
    localparam real HA       = 38.46;  // 13.0 MHz
    localparam real HB       = 37.31;  // 13.4 MHz
    localparam real PA       = 2.0 * HA;
    localparam real MIN_PH   = 37.0;

    logic       sys_clk = 1'b0;
    logic       rst_n   = 1'b0;
    logic       pri_is_a = 1'b1;
    logic       ref_a   = 1'b0;
    logic       ref_b   = 1'b0;
    logic       clk_out;
    logic [1:0] active_src;
    logic       switch_evt;

    bit run_a = 1'b1, run_b = 1'b1;
    int n_chk = 0, n_err = 0, runts = 0;
    bit gmon = 1'b0, done = 1'b0;
    real last_t = 0.0;
    logic [1:0] exp_q[$];

    refclk_failover u_refclk_failover (
        .sys_clk    (sys_clk),
        .rst_n      (rst_n),
        .pri_is_a   (pri_is_a),
        .ref_a      (ref_a),
        .ref_b      (ref_b),
        .clk_out    (clk_out),
        .active_src (active_src),
        .switch_evt (switch_evt)
    );

    always #(SYS_HALF) sys_clk = ~sys_clk;
    initial forever begin #(HA); if (run_a) ref_a = ~ref_a; end
    initial forever begin #(HB); if (run_b) ref_b = ~ref_b; end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic stop_a(input logic lvl);
        wait (ref_a == lvl);
        #1;
        run_a = 1'b0;
    endtask

    task automatic stop_b(input logic lvl);
        wait (ref_b == lvl);
        #1;
        run_b = 1'b0;
    endtask

    task automatic expect_switch(input logic [1:0] src);
        exp_q.push_back(src);
    endtask

    task automatic settle_check(input string tag, input logic [1:0] exp);
        @(negedge sys_clk);
        check(tag, 32'(active_src), 32'(exp));
    endtask

    // Scoreboard monitor: each event pops the expected new source (R9).
    always @(negedge sys_clk) begin
        if (rst_n && switch_evt) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_err++;
                $display("FAIL R9 unexpected switch: actual=%0h expected=none", active_src);
            end else begin
                logic [1:0] e;
                e = exp_q.pop_front();
                if (active_src !== e) begin
                    n_err++;
                    $display("FAIL R9 switch target: actual=%0h expected=%0h", active_src, e);
                end
            end
        end
    end

    // Phase-width monitor for R3.
    always @(clk_out) begin
        if (gmon) begin
            if (last_t > 0.0 && ($realtime - last_t) < MIN_PH) runts++;
            last_t = $realtime;
        end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #(900000.0);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        bit held_low;
        // R1: reset state with both references toggling
        repeat (8) @(posedge sys_clk);
        @(negedge sys_clk);
        check("R1 clk_out in reset", 32'(clk_out), 0);
        check("R1 active_src in reset", 32'(active_src), 0);
        check("R1 switch_evt in reset", 32'(switch_evt), 0);

        // R7/R8: primary A running at start -> A
        expect_switch(2'b01);
        rst_n = 1'b1;
        gmon = 1'b1;
        last_t = 0.0;
        #3000;
        settle_check("R8 A primary at start", 2'b01);

        // R2: active primary stops low -> backup B
        expect_switch(2'b10);
        stop_a(1'b0);
        #3000;
        settle_check("R2 loss low to backup", 2'b10);

        // R4: return needs the full qualification count
        run_a = 1'b1;
        #(1000.0 * PA);
        settle_check("R4 still backup before count", 2'b10);
        expect_switch(2'b01);
        #(24.0 * PA + 3000.0);
        settle_check("R4 primary after count", 2'b01);

        // R2/R3: primary stops stuck high -> forced clear, backup
        expect_switch(2'b10);
        stop_a(1'b1);
        #3000;
        settle_check("R2 loss high to backup", 2'b10);

        // R5: interrupted return restarts the count
        run_a = 1'b1;
        #(500.0 * PA);
        stop_a(1'b0);
        #2000;
        run_a = 1'b1;
        #(1000.0 * PA);
        settle_check("R5 count restarted", 2'b10);
        expect_switch(2'b01);
        #(24.0 * PA + 3000.0);
        settle_check("R5 primary after fresh count", 2'b01);

        // R8: select change moves to the new primary B
        expect_switch(2'b10);
        pri_is_a = 1'b0;
        #3000;
        settle_check("R8 select change to B", 2'b10);

        // R2: loss of the backup does not disturb the active primary
        stop_a(1'b0);
        #2000;
        settle_check("R2 backup loss ignored", 2'b10);

        // R6: both dead -> held low
        stop_b(1'b1);
        #3000;
        settle_check("R6 none active", 2'b00);
        held_low = 1'b1;
        for (int k = 0; k < 400; k++) begin
            @(negedge sys_clk);
            if (clk_out !== 1'b0) held_low = 1'b0;
        end
        check("R6 clk_out held low", 32'(held_low), 1);

        // R6: backup returning from idle is taken at once
        expect_switch(2'b01);
        run_a = 1'b1;
        #3000;
        settle_check("R6 backup adopted from idle", 2'b01);

        // R7: reset with the primary (B) dead -> start on backup A
        check("R9 all events seen before reset", 32'(exp_q.size()), 0);
        gmon = 1'b0;
        rst_n = 1'b0;
        #200;
        expect_switch(2'b01);
        last_t = 0.0;
        rst_n = 1'b1;
        gmon = 1'b1;
        #3000;
        settle_check("R7 start on backup", 2'b01);

        check("R3 no short output phase", 32'(runts), 0);
        check("R9 all expected events seen", 32'(exp_q.size()), 0);
        done = 1'b1;
        finish_run();
    end
endmodule